// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the register file of one ATA channel as a byte-wide host I/O bus sees it. There are two chip selects. One covers the eight task-file offsets. The other covers the two-byte control block. The host uses these registers to program the sector and cylinder parameters and to select one of two drive slots. It also issues a small set of commands and reads back status. Media access, packet parsing and identify data are outside this block.

Each drive slot has a type on an input pin: absent, disk or packet device. The block answers each command with a status/error update and an interrupt request. A soft reset is started and ended by edges of a bit in the device control register. The interrupt request is a level. It is gated by the interrupt-disable bit, and a read of the primary status register clears it. Each interrupt that is raised also sets a sticky bus-master interrupt flag.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After reset, for a present drive, reads give error 0x01, status 0x00, drive/head 0x00, sector count 0x01, sector number 0x01 and both cylinder bytes 0x00. The irq and bus-master flag are 0. Device control starts at 0x08, so interrupts are enabled.
- R2: Task-file offsets are: data 0, error (read) or features (write) 1, sector count 2, sector number 3, cylinder low 4, cylinder high 5, drive/head 6, status (read) or command (write) 7. A write to offsets 2 to 5 updates the copy held for both slots. A read returns the copy of the slot chosen by drive/head bit 4 (0 = master, 1 = slave).
- R3: A drive/head write stores the value with bits 7 and 5 forced to 1.
- R4: A drive/head write that selects an absent slot sets error bit 2 and status bit 0. Both bits persist after a present slot is selected again.
- R5: Control-block offset 1 always reads 0xFF. Control-block offset 0 reads status as the alternate status. Only address bit 0 is decoded in the control block. With the selected slot absent, drive/head reads 0xA0 and every other task-file offset and the alternate status read 0. Data offset 0 reads 0, and writes to offsets 0 and 1 change nothing readable.
- R6: A device-control write that takes bit 2 (soft reset) from 0 to 1 sets status 0x90 and error 0x01, drops a pending irq, and stores the value with bit 1 (interrupt disable) cleared.
- R7: A device-control write that takes bit 2 from 1 to 0 has these effects:
  - status bit 7 is cleared and status bit 6 is set;
  - the drive/head bits 3:0 are zeroed;
  - each slot gets sector count 1 and sector number 1;
  - each slot's cylinder becomes 0xEB14 for a packet device and 0x0000 otherwise.
  A write that leaves bit 2 unchanged only stores the value.
- R8: An abort sets status 0x41 and error 0x04 and raises an interrupt.
- R9: Command 0xEC on a disk, or 0xA1 on a packet device, sets error 0x00 and status 0x58 and raises an interrupt. Either command on any other slot type aborts (R8).
- R10: Commands 0xEF, 0x91 and 0x10 clear status bit 0, set status bits 6 and 4, leave the error register as it is and raise an interrupt. Command 0xEF also clears status bits 7 and 5. Other command codes change nothing readable.
- R11: Raising an interrupt sets irq and the sticky bus-master flag only when device-control bit 1 is 0. Irq then stays high until a read of task-file offset 7. Alternate status reads leave it set.
- R12: Drive type encoding is 2'b00 absent, 2'b01 disk, 2'b10 packet device; 2'b11 counts as absent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_tf_i | input | 1 | Task-file block select |
| cs_ctl_i | input | 1 | Control block select (wins if both set) |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| kind_m_i | input | 2 | Master slot type |
| kind_s_i | input | 2 | Slave slot type |
| irq_o | output | 1 | Interrupt request level |
| bm_irq_o | output | 1 | Sticky bus-master interrupt flag |

## Verification
Read data is combinational. The bench samples it 2 ns after the access is driven, before the clock edge that ends the access. Every register write, and the interrupt raised by a command, takes effect at that edge. The bench checks irq and the bus-master flag 1 ns after the edge, and later reads see the new values. A status read drops irq at its own edge, so the bench checks irq after that edge too. The sequence keeps alternate status reads before the primary read, to show that they do not clear it.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    localparam int TF_DW   = 8;
    localparam int TF_AW   = 3;
    localparam int N_SLOTS = 2;

    // slot type codes
    localparam logic [1:0] KIND_NONE = 2'b00;
    localparam logic [1:0] KIND_DISK = 2'b01;
    localparam logic [1:0] KIND_PKT  = 2'b10;

    // bit positions
    localparam int ST_BSY  = 7;
    localparam int ST_DRDY = 6;
    localparam int ST_DF   = 5;
    localparam int ST_DSC  = 4;
    localparam int ST_ERR  = 0;
    localparam int CTL_SRST = 2;
    localparam int CTL_NIEN = 1;
    localparam int DH_DEV   = 4;
    localparam int ERR_ABRT = 2;

    // fixed values
    localparam logic [7:0] ST_IN_RESET = 8'h90;
    localparam logic [7:0] ST_ABORTED  = 8'h41;
    localparam logic [7:0] ST_ID_READY = 8'h58;
    localparam logic [7:0] ERR_DIAG_OK = 8'h01;
    localparam logic [7:0] ERR_ABORTED = 8'h04;
    localparam logic [7:0] DH_ONES     = 8'hA0;
    localparam logic [7:0] ALT_ADDR_RD = 8'hFF;

    // commands
    localparam logic [7:0] CMD_ID_DISK = 8'hEC;
    localparam logic [7:0] CMD_ID_PKT  = 8'hA1;
    localparam logic [7:0] CMD_SETFEAT = 8'hEF;
    localparam logic [7:0] CMD_INITPRM = 8'h91;
    localparam logic [7:0] CMD_RECAL   = 8'h10;

    // task-file offsets
    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_ERR  = 3'd1;
    localparam logic [2:0] OFS_SC   = 3'd2;
    localparam logic [2:0] OFS_SN   = 3'd3;
    localparam logic [2:0] OFS_CL   = 3'd4;
    localparam logic [2:0] OFS_CH   = 3'd5;
    localparam logic [2:0] OFS_DH   = 3'd6;
    localparam logic [2:0] OFS_STAT = 3'd7;

    typedef struct packed {
        logic [TF_DW-1:0] status;
        logic [TF_DW-1:0] error;
        logic [TF_DW-1:0] dh;
        logic [TF_DW-1:0] ctrl;
        logic             irq;
        logic             bm;
    } core_state_t;

    function automatic logic kind_present(input logic [1:0] k);
        return (k == KIND_DISK) || (k == KIND_PKT);
    endfunction

endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
    import ata_tf_pkg::*;
(
    input  logic             cs_tf_i,
    input  logic             cs_ctl_i,
    input  logic [TF_AW-1:0] addr_i,
    input  logic             wr_i,
    input  logic             rd_i,
    output logic             wr_sc_o,
    output logic             wr_sn_o,
    output logic             wr_cl_o,
    output logic             wr_ch_o,
    output logic             wr_dh_o,
    output logic             wr_cmd_o,
    output logic             wr_ctl_o,
    output logic             rd_stat_o
);
    logic tf_sel;

    always_comb begin
        tf_sel    = cs_tf_i && !cs_ctl_i;
        wr_sc_o   = tf_sel && wr_i && (addr_i == OFS_SC);
        wr_sn_o   = tf_sel && wr_i && (addr_i == OFS_SN);
        wr_cl_o   = tf_sel && wr_i && (addr_i == OFS_CL);
        wr_ch_o   = tf_sel && wr_i && (addr_i == OFS_CH);
        wr_dh_o   = tf_sel && wr_i && (addr_i == OFS_DH);
        wr_cmd_o  = tf_sel && wr_i && (addr_i == OFS_STAT);
        wr_ctl_o  = cs_ctl_i && wr_i && !addr_i[0];
        rd_stat_o = tf_sel && rd_i && (addr_i == OFS_STAT);
    end
endmodule

// File: rtl/ata_tf_slot.sv
module ata_tf_slot
    import ata_tf_pkg::*;
#(
    parameter logic [15:0] PKT_CYL = 16'hEB14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sc_i,
    input  logic             wr_sn_i,
    input  logic             wr_cl_i,
    input  logic             wr_ch_i,
    input  logic [TF_DW-1:0] wdata_i,
    input  logic             rst_exit_i,
    input  logic [1:0]       kind_i,
    output logic [TF_DW-1:0] sc_o,
    output logic [TF_DW-1:0] sn_o,
    output logic [15:0]      cyl_o
);
    typedef struct packed {
        logic [TF_DW-1:0] sc;
        logic [TF_DW-1:0] sn;
        logic [15:0]      cyl;
    } slot_state_t;

    slot_state_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (rst_exit_i) begin
            slot_d.sc  = TF_DW'(1);
            slot_d.sn  = TF_DW'(1);
            slot_d.cyl = (kind_i == KIND_PKT) ? PKT_CYL : 16'h0000;
        end else begin
            if (wr_sc_i) slot_d.sc        = wdata_i;
            if (wr_sn_i) slot_d.sn        = wdata_i;
            if (wr_cl_i) slot_d.cyl[7:0]  = wdata_i;
            if (wr_ch_i) slot_d.cyl[15:8] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q.sc  <= TF_DW'(1);
            slot_q.sn  <= TF_DW'(1);
            slot_q.cyl <= 16'h0000;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign sc_o  = slot_q.sc;
    assign sn_o  = slot_q.sn;
    assign cyl_o = slot_q.cyl;

    // R7: leaving soft reset loads the per-type defaults
    p_exit_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_exit_i |=> (slot_q.sc == 8'd1) && (slot_q.sn == 8'd1) &&
                       (slot_q.cyl == (($past(kind_i) == KIND_PKT) ? PKT_CYL : 16'h0000)));

    // R2: a count write lands in this copy
    p_count_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sc_i && !rst_exit_i) |=> (slot_q.sc == $past(wdata_i)));
endmodule

// File: rtl/ata_tf_core.sv
module ata_tf_core
    import ata_tf_pkg::*;
#(
    parameter logic [TF_DW-1:0] CTRL_INIT = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_dh_i,
    input  logic             wr_cmd_i,
    input  logic             wr_ctl_i,
    input  logic             rd_stat_i,
    input  logic [TF_DW-1:0] wdata_i,
    input  logic [1:0]       kind_m_i,
    input  logic [1:0]       kind_s_i,
    output logic [TF_DW-1:0] status_o,
    output logic [TF_DW-1:0] error_o,
    output logic [TF_DW-1:0] dh_o,
    output logic             irq_o,
    output logic             bm_o,
    output logic             rst_exit_o
);
    core_state_t core_d, core_q;
    logic [1:0]  kind_cur;
    logic [1:0]  kind_new;
    logic        raise;
    logic        srst_rise;

    always_comb begin
        core_d     = core_q;
        raise      = 1'b0;
        rst_exit_o = 1'b0;
        srst_rise  = 1'b0;
        kind_cur   = core_q.dh[DH_DEV] ? kind_s_i : kind_m_i;
        kind_new   = wdata_i[DH_DEV] ? kind_s_i : kind_m_i;

        if (rd_stat_i) core_d.irq = 1'b0;

        if (wr_dh_i) begin
            core_d.dh = wdata_i | DH_ONES;
            if (!kind_present(kind_new)) begin
                core_d.error[ERR_ABRT] = 1'b1;
                core_d.status[ST_ERR]  = 1'b1;
            end
        end

        if (wr_ctl_i) begin
            core_d.ctrl = wdata_i;
            if (!core_q.ctrl[CTL_SRST] && wdata_i[CTL_SRST]) begin
                srst_rise                = 1'b1;
                core_d.status            = ST_IN_RESET;
                core_d.error             = ERR_DIAG_OK;
                core_d.irq               = 1'b0;
                core_d.ctrl[CTL_NIEN]    = 1'b0;
            end else if (core_q.ctrl[CTL_SRST] && !wdata_i[CTL_SRST]) begin
                rst_exit_o               = 1'b1;
                core_d.status[ST_BSY]    = 1'b0;
                core_d.status[ST_DRDY]   = 1'b1;
                core_d.dh[3:0]           = 4'h0;
            end
        end

        if (wr_cmd_i) begin
            case (wdata_i)
                CMD_ID_DISK, CMD_ID_PKT: begin
                    if (((wdata_i == CMD_ID_DISK) && (kind_cur == KIND_DISK)) ||
                        ((wdata_i == CMD_ID_PKT)  && (kind_cur == KIND_PKT))) begin
                        core_d.error  = '0;
                        core_d.status = ST_ID_READY;
                    end else begin
                        core_d.error  = ERR_ABORTED;
                        core_d.status = ST_ABORTED;
                    end
                    raise = 1'b1;
                end
                CMD_SETFEAT: begin
                    core_d.status[ST_BSY]  = 1'b0;
                    core_d.status[ST_DF]   = 1'b0;
                    core_d.status[ST_ERR]  = 1'b0;
                    core_d.status[ST_DRDY] = 1'b1;
                    core_d.status[ST_DSC]  = 1'b1;
                    raise = 1'b1;
                end
                CMD_INITPRM, CMD_RECAL: begin
                    core_d.status[ST_ERR]  = 1'b0;
                    core_d.status[ST_DRDY] = 1'b1;
                    core_d.status[ST_DSC]  = 1'b1;
                    raise = 1'b1;
                end
                default: ;
            endcase
        end

        if (raise && !core_q.ctrl[CTL_NIEN]) begin
            core_d.irq = 1'b1;
            core_d.bm  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.status <= '0;
            core_q.error  <= ERR_DIAG_OK;
            core_q.dh     <= '0;
            core_q.ctrl   <= CTRL_INIT;
            core_q.irq    <= 1'b0;
            core_q.bm     <= 1'b0;
        end else begin
            core_q <= core_d;
        end
    end

    assign status_o = core_q.status;
    assign error_o  = core_q.error;
    assign dh_o     = core_q.dh;
    assign irq_o    = core_q.irq;
    assign bm_o     = core_q.bm;

    // R11: a new request only appears with interrupts enabled, and the bus-master flag follows it
    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_q.irq) |-> (!core_q.ctrl[CTL_NIEN] && core_q.bm));

    // R11: a primary status read drops the request
    p_stat_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_i |=> !core_q.irq);

    // R6: entering soft reset
    p_reset_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst_rise |=> (core_q.status == ST_IN_RESET) && (core_q.error == ERR_DIAG_OK) &&
                      !core_q.irq && !core_q.ctrl[CTL_NIEN]);

    // R8: identify on a disk-less selection aborts
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd_i && (wdata_i == CMD_ID_DISK) && (kind_cur != KIND_DISK))
            |=> (core_q.status == ST_ABORTED) && (core_q.error == ERR_ABORTED));

    // R3: stored drive/head always carries the forced bits
    p_dh_forced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dh_i |=> (core_q.dh[7] && core_q.dh[5]));

    // R11: the bus-master flag never drops once set
    p_bm_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.bm |=> core_q.bm);
endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
    import ata_tf_pkg::*;
(
    input  logic             cs_tf_i,
    input  logic             cs_ctl_i,
    input  logic [TF_AW-1:0] addr_i,
    input  logic             present_i,
    input  logic [TF_DW-1:0] status_i,
    input  logic [TF_DW-1:0] error_i,
    input  logic [TF_DW-1:0] dh_i,
    input  logic [TF_DW-1:0] sc_i,
    input  logic [TF_DW-1:0] sn_i,
    input  logic [15:0]      cyl_i,
    output logic [TF_DW-1:0] rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (cs_ctl_i) begin
            if (addr_i[0])      rdata_o = ALT_ADDR_RD;
            else if (present_i) rdata_o = status_i;
        end else if (cs_tf_i) begin
            if (!present_i) begin
                rdata_o = (addr_i == OFS_DH) ? DH_ONES : '0;
            end else begin
                case (addr_i)
                    OFS_ERR:  rdata_o = error_i;
                    OFS_SC:   rdata_o = sc_i;
                    OFS_SN:   rdata_o = sn_i;
                    OFS_CL:   rdata_o = cyl_i[7:0];
                    OFS_CH:   rdata_o = cyl_i[15:8];
                    OFS_DH:   rdata_o = dh_i;
                    OFS_STAT: rdata_o = status_i;
                    default:  rdata_o = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter logic [15:0]      PKT_CYL   = 16'hEB14,
    parameter logic [TF_DW-1:0] CTRL_INIT = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_tf_i,
    input  logic             cs_ctl_i,
    input  logic [TF_AW-1:0] addr_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [TF_DW-1:0] wdata_i,
    output logic [TF_DW-1:0] rdata_o,
    input  logic [1:0]       kind_m_i,
    input  logic [1:0]       kind_s_i,
    output logic             irq_o,
    output logic             bm_irq_o
);
    logic wr_sc, wr_sn, wr_cl, wr_ch, wr_dh, wr_cmd, wr_ctl, rd_stat;
    logic rst_exit;
    logic [TF_DW-1:0] status, error, dh;
    logic [1:0]       kind_arr [N_SLOTS];
    logic [TF_DW-1:0] sc_arr   [N_SLOTS];
    logic [TF_DW-1:0] sn_arr   [N_SLOTS];
    logic [15:0]      cyl_arr  [N_SLOTS];
    logic             sel;

    assign kind_arr[0] = kind_m_i;
    assign kind_arr[1] = kind_s_i;
    assign sel         = dh[DH_DEV];

    ata_tf_decode u_decode (
        .cs_tf_i  (cs_tf_i),
        .cs_ctl_i (cs_ctl_i),
        .addr_i   (addr_i),
        .wr_i     (wr_i),
        .rd_i     (rd_i),
        .wr_sc_o  (wr_sc),
        .wr_sn_o  (wr_sn),
        .wr_cl_o  (wr_cl),
        .wr_ch_o  (wr_ch),
        .wr_dh_o  (wr_dh),
        .wr_cmd_o (wr_cmd),
        .wr_ctl_o (wr_ctl),
        .rd_stat_o(rd_stat)
    );

    ata_tf_core #(.CTRL_INIT(CTRL_INIT)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dh_i   (wr_dh),
        .wr_cmd_i  (wr_cmd),
        .wr_ctl_i  (wr_ctl),
        .rd_stat_i (rd_stat),
        .wdata_i   (wdata_i),
        .kind_m_i  (kind_m_i),
        .kind_s_i  (kind_s_i),
        .status_o  (status),
        .error_o   (error),
        .dh_o      (dh),
        .irq_o     (irq_o),
        .bm_o      (bm_irq_o),
        .rst_exit_o(rst_exit)
    );

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        ata_tf_slot #(.PKT_CYL(PKT_CYL)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_sc_i   (wr_sc),
            .wr_sn_i   (wr_sn),
            .wr_cl_i   (wr_cl),
            .wr_ch_i   (wr_ch),
            .wdata_i   (wdata_i),
            .rst_exit_i(rst_exit),
            .kind_i    (kind_arr[g]),
            .sc_o      (sc_arr[g]),
            .sn_o      (sn_arr[g]),
            .cyl_o     (cyl_arr[g])
        );
    end

    ata_tf_rdmux u_rdmux (
        .cs_tf_i  (cs_tf_i),
        .cs_ctl_i (cs_ctl_i),
        .addr_i   (addr_i),
        .present_i(kind_present(kind_arr[sel])),
        .status_i (status),
        .error_i  (error),
        .dh_i     (dh),
        .sc_i     (sc_arr[sel]),
        .sn_i     (sn_arr[sel]),
        .cyl_i    (cyl_arr[sel]),
        .rdata_o  (rdata_o)
    );

    // R2: both slot copies agree after any parameter write
    p_copies_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sc |=> (sc_arr[0] == sc_arr[1]));
endmodule

// File: tb/test_ata_taskfile_ctrl.sv
module test_ata_taskfile_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_tf = 1'b0, cs_ctl = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] k_m = 2'b01, k_s = 2'b00;
    logic       irq, bm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_stat, m_err, m_dh, m_ctrl;
    logic [7:0] m_sc[2], m_sn[2], m_cl[2], m_ch[2];
    logic       m_irq, m_bm;

    always #4 clk = ~clk;

    ata_taskfile_ctrl i_ata_taskfile_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_tf_i(cs_tf), .cs_ctl_i(cs_ctl), .addr_i(addr),
        .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata),
        .kind_m_i(k_m), .kind_s_i(k_s), .irq_o(irq), .bm_irq_o(bm)
    );

    function automatic bit pres(input logic [1:0] k);
        return (k == 2'b01) || (k == 2'b10);
    endfunction

    function automatic logic [1:0] kind_of(input bit s);
        return s ? k_s : k_m;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic void m_reset();
        m_stat = 8'h00; m_err = 8'h01; m_dh = 8'h00; m_ctrl = 8'h08;
        m_irq = 0; m_bm = 0;
        for (int i = 0; i < 2; i++) begin
            m_sc[i] = 8'h01; m_sn[i] = 8'h01; m_cl[i] = 8'h00; m_ch[i] = 8'h00;
        end
    endfunction

    function automatic logic [7:0] m_read(input bit ctl, input logic [2:0] a);
        bit s = m_dh[4];
        bit p = pres(kind_of(s));
        if (ctl) return a[0] ? 8'hFF : (p ? m_stat : 8'h00);
        if (!p) return (a == 3'd6) ? 8'hA0 : 8'h00;
        case (a)
            3'd1: return m_err;
            3'd2: return m_sc[s];
            3'd3: return m_sn[s];
            3'd4: return m_cl[s];
            3'd5: return m_ch[s];
            3'd6: return m_dh;
            3'd7: return m_stat;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void m_raise();
        if (!m_ctrl[1]) begin m_irq = 1; m_bm = 1; end
    endfunction

    function automatic void m_abort();
        m_stat = 8'h41; m_err = 8'h04; m_raise();
    endfunction

    function automatic void m_apply(input bit ctl, input bit w, input logic [2:0] a, input logic [7:0] d);
        logic [1:0] kc;
        if (!w) begin
            if (!ctl && a == 3'd7) m_irq = 0;
            return;
        end
        if (ctl) begin
            if (a[0]) return;
            if (!m_ctrl[2] && d[2]) begin
                m_stat = 8'h90; m_err = 8'h01; m_irq = 0; m_ctrl = d & 8'hFD;
            end else begin
                if (m_ctrl[2] && !d[2]) begin
                    m_stat = (m_stat & 8'h7F) | 8'h40;
                    m_dh = m_dh & 8'hF0;
                    for (int i = 0; i < 2; i++) begin
                        m_sc[i] = 8'h01; m_sn[i] = 8'h01;
                        m_cl[i] = (kind_of(i[0]) == 2'b10) ? 8'h14 : 8'h00;
                        m_ch[i] = (kind_of(i[0]) == 2'b10) ? 8'hEB : 8'h00;
                    end
                end
                m_ctrl = d;
            end
            return;
        end
        kc = kind_of(m_dh[4]);
        case (a)
            3'd2: begin m_sc[0] = d; m_sc[1] = d; end
            3'd3: begin m_sn[0] = d; m_sn[1] = d; end
            3'd4: begin m_cl[0] = d; m_cl[1] = d; end
            3'd5: begin m_ch[0] = d; m_ch[1] = d; end
            3'd6: begin
                m_dh = d | 8'hA0;
                if (!pres(kind_of(d[4]))) begin m_err = m_err | 8'h04; m_stat = m_stat | 8'h01; end
            end
            3'd7: begin
                if (d == 8'hEC) begin
                    if (kc == 2'b01) begin m_err = 0; m_stat = 8'h58; m_raise(); end else m_abort();
                end else if (d == 8'hA1) begin
                    if (kc == 2'b10) begin m_err = 0; m_stat = 8'h58; m_raise(); end else m_abort();
                end else if (d == 8'hEF) begin
                    m_stat = (m_stat & 8'h5E) | 8'h50; m_raise();
                end else if (d == 8'h91 || d == 8'h10) begin
                    m_stat = (m_stat & 8'hFE) | 8'h50; m_raise();
                end
            end
            default: ;
        endcase
    endfunction

    // one bus access: read data sampled mid-cycle, flags after the edge
    task automatic op(input bit ctl, input bit w, input logic [2:0] a, input logic [7:0] d,
                      input string tag, output logic [7:0] q);
        logic [7:0] exp_rd;
        exp_rd = m_read(ctl, a);
        @(negedge clk);
        cs_tf = !ctl; cs_ctl = ctl; addr = a; wr = w; rd = !w; wdata = d;
        #2;
        q = rdata;
        if (!w) chk({tag, " read"}, q, exp_rd);
        m_apply(ctl, w, a, d);
        @(posedge clk);
        #1;
        cs_tf = 0; cs_ctl = 0; wr = 0; rd = 0;
        chk({tag, " irq"}, {7'd0, irq}, {7'd0, m_irq});
        chk({tag, " bm"},  {7'd0, bm},  {7'd0, m_bm});
    endtask

    task automatic wt(input logic [2:0] a, input logic [7:0] d, input string tag);
        logic [7:0] q;
        op(0, 1, a, d, tag, q);
    endtask

    task automatic wc(input logic [7:0] d, input string tag);
        logic [7:0] q;
        op(1, 1, 3'd0, d, tag, q);
    endtask

    task automatic rt(input logic [2:0] a, input logic [7:0] lit, input string tag);
        logic [7:0] q;
        op(0, 0, a, 8'h00, tag, q);
        chk({tag, " literal"}, q, lit);
    endtask

    task automatic rc(input logic [2:0] a, input logic [7:0] lit, input string tag);
        logic [7:0] q;
        op(1, 0, a, 8'h00, tag, q);
        chk({tag, " literal"}, q, lit);
    endtask

    initial begin
        logic [7:0] q;
        m_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq at reset", {7'd0, irq}, 8'h00);

        // R1: power-up values (master disk)
        rt(3'd1, 8'h01, "R1 error");
        rt(3'd7, 8'h00, "R1 status");
        rt(3'd6, 8'h00, "R1 dh");
        rt(3'd2, 8'h01, "R1 sc");
        rt(3'd3, 8'h01, "R1 sn");
        rt(3'd4, 8'h00, "R1 cl");
        rt(3'd5, 8'h00, "R1 ch");

        // R2: shared parameter copies
        k_s = 2'b01;
        wt(3'd2, 8'h11, "R2 w sc"); wt(3'd3, 8'h22, "R2 w sn");
        wt(3'd4, 8'h33, "R2 w cl"); wt(3'd5, 8'h44, "R2 w ch");
        wt(3'd6, 8'h10, "R2 sel slave");
        rt(3'd2, 8'h11, "R2 slave sc"); rt(3'd5, 8'h44, "R2 slave ch");
        wt(3'd6, 8'h00, "R2 sel master");
        rt(3'd3, 8'h22, "R2 master sn"); rt(3'd4, 8'h33, "R2 master cl");

        // R3: forced bits
        wt(3'd6, 8'h4B, "R3 w dh");
        rt(3'd6, 8'hEB, "R3 dh");

        // R9 + R11: identify, alt status does not clear, primary does
        wt(3'd7, 8'hEC, "R9 ident disk");
        rc(3'd0, 8'h58, "R11 alt status keeps irq");
        rt(3'd1, 8'h00, "R9 error");
        rt(3'd7, 8'h58, "R11 status read clears irq");

        // R8: packet identify on a disk aborts
        wt(3'd7, 8'hA1, "R8 mismatch");
        rt(3'd1, 8'h04, "R8 error");
        rt(3'd7, 8'h41, "R8 status");

        // R10: set features keeps error register
        wt(3'd7, 8'hEF, "R10 set features");
        rt(3'd7, 8'h50, "R10 status");
        rt(3'd1, 8'h04, "R10 error kept");
        wt(3'd7, 8'h20, "R10 unknown cmd");
        rt(3'd7, 8'h50, "R10 unknown no change");

        // R11: interrupt disabled
        wc(8'h02, "R11 nien");
        wt(3'd7, 8'h91, "R11 masked");
        chk("R11 masked irq", {7'd0, irq}, 8'h00);

        // R6: reset entry clears nIEN
        k_s = 2'b10;
        wt(3'd6, 8'h1F, "R6 sel slave pkt");
        wc(8'h06, "R6 srst rise");
        rt(3'd7, 8'h90, "R6 status");
        rt(3'd1, 8'h01, "R6 error");
        wc(8'h04, "R7 srst held");
        rt(3'd7, 8'h90, "R7 held no change");
        wt(3'd7, 8'h10, "R6 irq enabled in reset");
        chk("R6 irq enabled", {7'd0, irq}, 8'h01);
        rt(3'd7, 8'hD0, "R6 status after cmd");

        // R7: reset exit
        wt(3'd2, 8'h77, "R7 pre sc");
        wc(8'h00, "R7 srst fall");
        rt(3'd7, 8'h50, "R7 status");
        rt(3'd6, 8'hB0, "R7 head zero");
        rt(3'd2, 8'h01, "R7 sc");
        rt(3'd3, 8'h01, "R7 sn");
        rt(3'd4, 8'h14, "R7 pkt cl");
        rt(3'd5, 8'hEB, "R7 pkt ch");
        wt(3'd6, 8'h00, "R7 sel master");
        rt(3'd5, 8'h00, "R7 disk ch");
        wt(3'd7, 8'hA1, "R12 disk code rejects A1");
        rt(3'd7, 8'h41, "R12 abort");

        // R4 + R5: absent slave
        k_s = 2'b11;
        wt(3'd6, 8'h10, "R4 sel absent");
        rt(3'd6, 8'hA0, "R5 absent dh");
        rt(3'd2, 8'h00, "R5 absent sc");
        rt(3'd7, 8'h00, "R5 absent status");
        rc(3'd0, 8'h00, "R5 absent alt");
        rc(3'd1, 8'hFF, "R5 alt addr");
        wt(3'd6, 8'h00, "R4 sel master");
        rt(3'd1, 8'h04, "R4 error abort bit");
        rt(3'd7, 8'h41, "R4 status err bit");
        wt(3'd0, 8'h99, "R5 data write");
        wt(3'd1, 8'h99, "R5 features write");
        rt(3'd0, 8'h00, "R5 data read");
        rt(3'd1, 8'h04, "R5 error unchanged");
        rc(3'd7, 8'hFF, "R5 ctl bit0 only");

        // random phase
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 9);
            if (i % 400 == 0) begin
                k_m = 2'($urandom_range(0, 3));
                k_s = 2'($urandom_range(0, 3));
            end
            case (sel)
                0, 1: op(0, 0, 3'($urandom_range(0, 7)), 8'h00, "R2 rand rd", q);
                2:    op(1, 0, 3'($urandom_range(0, 7)), 8'h00, "R5 rand ctl rd", q);
                3:    op(0, 1, 3'($urandom_range(2, 5)), 8'($urandom), "R2 rand param", q);
                4:    op(0, 1, 3'd6, 8'($urandom), "R4 rand dh", q);
                5, 6: begin
                    logic [7:0] cmds [8] = '{8'hEC, 8'hA1, 8'hEF, 8'h91, 8'h10, 8'h20, 8'hC6, 8'h00};
                    op(0, 1, 3'd7, cmds[$urandom_range(0, 7)], "R9 rand cmd", q);
                end
                7:    op(1, 1, 3'd0, (8'($urandom) & 8'h06) | 8'h08, "R6 rand ctrl", q);
                default: op(0, 0, 3'd7, 8'h00, "R11 rand status", q);
            endcase
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule